// File: doc/BRIEF.md
# Flash Line Prefetch Buffer

This block connects a 32-bit processor read port to an on-chip flash array whose read path is 128 bits wide. Every flash access brings back one 16-byte line. Two line buffers keep recently used lines. One holds the line the processor is reading from. The other is filled in the background with the next sequential line. Because of this, a linear instruction stream rarely stalls, even when the flash needs several wait states per access.

A processor read carries a byte address and a transfer size. If the addressed line is already in a buffer, the read completes in the same cycle. If it is not, ready stays low while the flash fetches the line, and the read completes in the cycle after the line arrives. A programmable wait-state count sets how long each flash access lasts. The flash is smaller than the address window it sits in, so its contents repeat across that window. An invalidate input, for use after the flash contents change, empties both buffers.

Top module: `fpb_top`

## Requirements
- R1: A read whose line is held in a valid buffer is accepted in the same cycle it is presented: `req_ready` is high and `rsp_data` carries the addressed data in that cycle.
- R2: A read whose line is in neither buffer, and is not already being fetched, keeps `req_ready` low for exactly `wait_states`+1 cycles and completes in the following cycle. No read ever waits longer than `wait_states`+1 cycles.
- R3: With `wait_states` equal to 0, a flash access lasts one cycle, so a missing read costs exactly one stall cycle.
- R4: After a line becomes current, the block fetches the next sequential line (line index + 1) into the other buffer while the flash is idle. A stream of consecutive word reads then runs without stalls whenever `wait_states` is 2 or less. The two buffers never hold the same line.
- R5: Idle cycles between reads do not discard a prefetched line. A read of it after any number of idle cycles completes with no stall.
- R6: Only address bits below log2 of the flash size select data, so addresses that differ by a multiple of the flash size return the same bytes. The line after the last flash line is line 0, and it is prefetched like any other line.
- R7: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. Within the line, address bits [3:2] pick the 32-bit word. A byte read returns the byte picked by address bits [1:0], and a halfword read returns the halfword picked by address bit 1. Both are zero-extended into `rsp_data`.
- R8: An invalidate pulse clears both buffers and cancels any flash access in progress. The next read of a line that was held before the pulse misses and pays the full `wait_states`+1 stall.
- R9: A missing read for a line other than the one being prefetched abandons that prefetch and starts its own access at once, so it completes after `wait_states`+1 stall cycles. A read for the line currently being prefetched waits only for that access to finish.
- R10: `fl_line` holds one line address for the whole length of an access, and only one access is in progress at a time. `fl_data` is captured in the access's last cycle.
- R11: After reset both buffers are empty and the flash port is idle, so the first read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present; held with its address until accepted |
| req_addr | input | ADDR_W | Byte address inside the reserved window |
| req_size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| req_ready | output | 1 | Read accepted this cycle; `rsp_data` is valid |
| rsp_data | output | 32 | Read data, zero-extended for byte and halfword reads |
| wait_states | input | WS_W | Extra cycles per flash line access |
| invalidate | input | 1 | Clears both buffers and cancels any flash access |
| fl_en | output | 1 | Flash access in progress this cycle |
| fl_line | output | FLASH_AW-4 | Line index being read from the flash |
| fl_data | input | 128 | Line data from the flash for `fl_line` |

## Verification
The hardest situations to reach from the ports are the two ways a read can meet a background fetch already in progress. In one, the read asks for a different line, and the fetch must be dropped in favour of the read. In the other, the read asks for the very line being fetched, and it must join that fetch and not start a second one. Both depend on when the read arrives relative to the start of the prefetch. Directed sequences use a large wait-state count and issue the conflicting read in the cycle right after a line's first hit, when the prefetch has just started. The resulting stall lengths are then checked against `wait_states`+1 and `wait_states`. Random sequential runs with random jumps, gaps and sizes then cover the remaining interleavings.

// File: rtl/fpb_pkg.sv
// Package: shared types and constants for the flash line prefetch buffer.
// Assumes a two-entry line store, so one bit names a slot.
package fpb_pkg;
    localparam int LINE_BYTES = 16;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int NSLOT      = 2;
    localparam int SLOT_W     = 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_t;
endpackage

// File: rtl/fpb_line_store.sv
// Module: two line buffers, each with a valid bit and a line tag.
// Looks up the requested line across all slots and returns the hit slot and
// its data. A fill writes a line into one slot. An alloc marks a slot empty
// when an access starts to overwrite it. A flush empties every slot.
// Assumes fill and alloc never address two different slots in one cycle.
module fpb_line_store
    import fpb_pkg::*;
#(
    parameter int LINE_AW = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush_i,
    input  logic [LINE_AW-1:0]               lookup_line_i,
    output logic                             hit_o,
    output logic [SLOT_W-1:0]                hit_slot_o,
    output logic [LINE_W-1:0]                hit_data_o,
    input  logic                             alloc_i,
    input  logic [SLOT_W-1:0]                alloc_slot_i,
    input  logic                             fill_i,
    input  logic [SLOT_W-1:0]                fill_slot_i,
    input  logic [LINE_AW-1:0]               fill_line_i,
    input  logic [LINE_W-1:0]                fill_data_i,
    output logic [NSLOT-1:0]                 vld_o,
    output logic [NSLOT-1:0][LINE_AW-1:0]    tag_o
);
    logic [NSLOT-1:0]              vld_q;
    logic [NSLOT-1:0][LINE_AW-1:0] tag_q;
    logic [LINE_W-1:0]             data_q [NSLOT];
    logic [NSLOT-1:0]              match;

    // Per-slot tag comparison against the requested line.
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lookup_line_i);
    end

    // Priority pick of the matching slot and its line data.
    always_comb begin
        hit_o      = 1'b0;
        hit_slot_o = '0;
        hit_data_o = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (match[i] && !hit_o) begin
                hit_o      = 1'b1;
                hit_slot_o = SLOT_W'(i);
                hit_data_o = data_q[i];
            end
        end
    end

    // Valid and tag update: flush first, then fill, then alloc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            tag_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (flush_i) begin
                    vld_q[i] <= 1'b0;
                end else if (fill_i && fill_slot_i == SLOT_W'(i)) begin
                    vld_q[i] <= 1'b1;
                    tag_q[i] <= fill_line_i;
                end else if (alloc_i && alloc_slot_i == SLOT_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // Line data capture; no reset needed because valid guards it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (fill_i && !flush_i && fill_slot_i == SLOT_W'(i)) begin
                data_q[i] <= fill_data_i;
            end
        end
    end

    assign vld_o = vld_q;
    assign tag_o = tag_q;

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q == '0));

    // R4
    no_dup_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&vld_q) |-> (tag_q[0] != tag_q[1]));
endmodule

// File: rtl/fpb_fetch_seq.sv
// Module: flash access sequencer. Starts demand accesses on misses and
// prefetches of the line after the current one while the port is free. It
// counts wait states and raises fill in the last cycle of each access. A
// demand miss for another line drops a running prefetch. A miss for the
// in-flight line waits for that access. Assumes a two-slot store and that
// the requester holds its address until accepted.
module fpb_fetch_seq
    import fpb_pkg::*;
#(
    parameter int LINE_AW = 8,
    parameter int WS_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic [LINE_AW-1:0]            req_line_i,
    input  logic                          hit_i,
    input  logic [SLOT_W-1:0]             hit_slot_i,
    input  logic                          invalidate_i,
    input  logic [WS_W-1:0]               wait_states_i,
    input  logic [NSLOT-1:0]              vld_i,
    input  logic [NSLOT-1:0][LINE_AW-1:0] tag_i,
    output logic                          fl_en_o,
    output logic [LINE_AW-1:0]            fl_line_o,
    output logic                          alloc_o,
    output logic [SLOT_W-1:0]             alloc_slot_o,
    output logic                          fill_o,
    output logic [SLOT_W-1:0]             fill_slot_o
);
    logic                busy_q, pf_q;
    logic [WS_W-1:0]     cnt_q, ws_q;
    logic [LINE_AW-1:0]  line_q;
    logic [SLOT_W-1:0]   slot_q, cur_q;

    logic [LINE_AW-1:0]  nxt_line;
    logic                nxt_present, miss, join_inflight, req_blocks;
    logic                start_dem, start_pf, start, done, dem_fill;
    logic [SLOT_W-1:0]   tgt_slot;

    // Next-line target: wraps inside the flash because the tag is narrow.
    always_comb begin
        nxt_line    = tag_i[cur_q] + LINE_AW'(1);
        nxt_present = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (vld_i[i] && tag_i[i] == nxt_line) nxt_present = 1'b1;
        end
    end

    // Start, abort and completion decisions for the flash port.
    always_comb begin
        tgt_slot      = cur_q ^ SLOT_W'(1);
        miss          = req_valid_i && !hit_i && !invalidate_i;
        join_inflight = busy_q && (line_q == req_line_i);
        start_dem     = miss && !join_inflight && (!busy_q || pf_q);
        req_blocks    = req_valid_i && (!hit_i || hit_slot_i != cur_q);
        start_pf      = !busy_q && !req_blocks && !invalidate_i &&
                        vld_i[cur_q] && !nxt_present;
        start         = start_dem || start_pf;
        fl_line_o     = start_dem ? req_line_i : (start_pf ? nxt_line : line_q);
        fl_en_o       = start || (busy_q && !invalidate_i);
        done          = start ? (wait_states_i == '0)
                              : (busy_q && cnt_q == ws_q);
        fill_o        = done && !invalidate_i;
        fill_slot_o   = start ? tgt_slot : slot_q;
        alloc_o       = start;
        alloc_slot_o  = tgt_slot;
        dem_fill      = start ? start_dem : !pf_q;
    end

    // Access state, wait counter and current-slot tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pf_q   <= 1'b0;
            cnt_q  <= '0;
            ws_q   <= '0;
            line_q <= '0;
            slot_q <= '0;
            cur_q  <= '0;
        end else begin
            if (invalidate_i) begin
                busy_q <= 1'b0;
            end else if (start) begin
                line_q <= fl_line_o;
                slot_q <= tgt_slot;
                pf_q   <= !start_dem;
                ws_q   <= wait_states_i;
                cnt_q  <= WS_W'(1);
                busy_q <= (wait_states_i != '0);
            end else if (busy_q) begin
                if (cnt_q == ws_q) busy_q <= 1'b0;
                else               cnt_q  <= cnt_q + WS_W'(1);
            end
            if (fill_o && dem_fill)
                cur_q <= fill_slot_o;
            else if (req_valid_i && hit_i && !invalidate_i)
                cur_q <= hit_slot_i;
        end
    end

    // R2
    wait_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0 && cnt_q <= ws_q));

    // R10
    one_access_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !invalidate_i && !start_dem) |-> (fl_line_o == line_q));
endmodule

// File: rtl/fpb_lane_sel.sv
// Module: picks the addressed 32-bit word out of a 128-bit line, then the
// byte or halfword lane for narrow reads, zero-extended to 32 bits.
// Assumes halfword and word reads are naturally aligned.
module fpb_lane_sel
    import fpb_pkg::*;
(
    input  logic [LINE_W-1:0] line_i,
    input  logic [3:0]        offs_i,
    input  xfer_size_t        size_i,
    output logic [31:0]       data_o
);
    logic [31:0] word;

    // Word select by offset bits [3:2], then lane select by size.
    always_comb begin
        word = line_i[{offs_i[3:2], 5'b0} +: 32];
        case (size_i)
            SZ_BYTE: data_o = {24'b0, word[{offs_i[1:0], 3'b0} +: 8]};
            SZ_HALF: data_o = {16'b0, word[{offs_i[1], 4'b0} +: 16]};
            default: data_o = word;
        endcase
    end
endmodule

// File: rtl/fpb_top.sv
// Module: flash line prefetch buffer top. A 32-bit read port with a
// same-cycle ready handshake sits in front of a 128-bit flash line port.
// Address bits at and above FLASH_AW are ignored, so the flash repeats
// across the window. Assumes req_addr and req_size are held until
// req_ready, and that wait_states changes only while the flash is idle.
module fpb_top
    import fpb_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int FLASH_AW = 12,
    parameter int WS_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    output logic                 req_ready,
    output logic [31:0]          rsp_data,
    input  logic [WS_W-1:0]      wait_states,
    input  logic                 invalidate,
    output logic                 fl_en,
    output logic [FLASH_AW-5:0]  fl_line,
    input  logic [127:0]         fl_data
);
    localparam int LINE_AW = FLASH_AW - 4;

    logic [LINE_AW-1:0]          req_line;
    logic                        hit, alloc, fill;
    logic [SLOT_W-1:0]           hit_slot, alloc_slot, fill_slot;
    logic [LINE_W-1:0]           hit_data;
    logic [NSLOT-1:0]            vld;
    logic [NSLOT-1:0][LINE_AW-1:0] tag;
    logic                        addr_unused;

    // Wrap: only in-flash address bits form the line index.
    assign req_line    = req_addr[FLASH_AW-1:4];
    assign addr_unused = ^req_addr[ADDR_W-1:FLASH_AW];

    fpb_line_store #(.LINE_AW(LINE_AW)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (invalidate),
        .lookup_line_i (req_line),
        .hit_o         (hit),
        .hit_slot_o    (hit_slot),
        .hit_data_o    (hit_data),
        .alloc_i       (alloc),
        .alloc_slot_i  (alloc_slot),
        .fill_i        (fill),
        .fill_slot_i   (fill_slot),
        .fill_line_i   (fl_line),
        .fill_data_i   (fl_data),
        .vld_o         (vld),
        .tag_o         (tag)
    );

    fpb_fetch_seq #(.LINE_AW(LINE_AW), .WS_W(WS_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_line_i    (req_line),
        .hit_i         (hit),
        .hit_slot_i    (hit_slot),
        .invalidate_i  (invalidate),
        .wait_states_i (wait_states),
        .vld_i         (vld),
        .tag_i         (tag),
        .fl_en_o       (fl_en),
        .fl_line_o     (fl_line),
        .alloc_o       (alloc),
        .alloc_slot_o  (alloc_slot),
        .fill_o        (fill),
        .fill_slot_o   (fill_slot)
    );

    fpb_lane_sel u_lane (
        .line_i (hit_data),
        .offs_i (req_addr[3:0]),
        .size_i (xfer_size_t'(req_size)),
        .data_o (rsp_data)
    );

    // Ready handshake: a buffer hit completes in the cycle it is presented.
    assign req_ready = req_valid && hit && !invalidate;

    // R2
    stall_has_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !invalidate) |-> fl_en);
endmodule

// File: tb/fpb_top_bench.sv
// Bench: directed corner cases, then seeded random reads, with expected
// data and stall limits computed from a bench flash model.
module fpb_top_bench;
    localparam int ADDR_W   = 16;
    localparam int FLASH_AW = 12;
    localparam int WS_W     = 3;
    localparam int LINE_AW  = FLASH_AW - 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [1:0]          req_size = 2'd2;
    logic                req_ready;
    logic [31:0]         rsp_data;
    logic [WS_W-1:0]     wait_states = 3'd2;
    logic                invalidate = 1'b0;
    logic                fl_en;
    logic [LINE_AW-1:0]  fl_line;
    logic [127:0]        fl_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fpb_top #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .WS_W(WS_W)) u_fpb_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_ready(req_ready), .rsp_data(rsp_data),
        .wait_states(wait_states), .invalidate(invalidate), .fl_en(fl_en),
        .fl_line(fl_line), .fl_data(fl_data)
    );

    function automatic logic [31:0] mem_word(input int line, input int w);
        return (32'(line) * 32'h0100_0193) ^ (32'(w) * 32'h9E37_79B9) ^ 32'h5A5A_1234;
    endfunction

    // Flash model: combinational line read.
    assign fl_data = {mem_word(int'(fl_line), 3), mem_word(int'(fl_line), 2),
                      mem_word(int'(fl_line), 1), mem_word(int'(fl_line), 0)};

    function automatic logic [31:0] expect_rd(input logic [15:0] a, input logic [1:0] sz);
        logic [31:0] w;
        w = mem_word(int'(a[FLASH_AW-1:4]), int'(a[3:2]));
        case (sz)
            2'd0:    return (w >> (int'(a[1:0]) * 8)) & 32'hFF;
            2'd1:    return (w >> (int'(a[1]) * 16)) & 32'hFFFF;
            default: return w;
        endcase
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] sz, input int exp_lat,
                      input string rq, output int lat);
        lat = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        #4;
        while (!req_ready && lat < 1000) begin
            lat++;
            @(negedge clk);
            #4;
        end
        check(rq, "data", rsp_data, expect_rd(a, sz));
        if (exp_lat >= 0) check(rq, "stall cycles", 32'(lat), 32'(exp_lat));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic set_ws(input int v);
        idle(10);
        wait_states = WS_W'(v);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int lat;
        logic [15:0] a;
        logic [1:0]  sz;
        logic [15:0] ad;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        #4;
        // R11: idle port after reset, nothing fetched
        check("R11", "fl_en after reset", 32'(fl_en), 32'd0);
        check("R11", "ready after reset", 32'(req_ready), 32'd0);

        // R2, R11: first read misses, wait_states=2 gives 3 stall cycles
        rd(16'h0000, 2'd2, 3, "R2", lat);
        rd(16'h0004, 2'd2, 0, "R1", lat);
        rd(16'h0008, 2'd2, 0, "R1", lat);
        rd(16'h000C, 2'd2, 0, "R1", lat);
        // R4: next line was prefetched in the background
        rd(16'h0010, 2'd2, 0, "R4", lat);
        // R5: long idle gap keeps the prefetched line
        idle(20);
        rd(16'h0020, 2'd2, 0, "R5", lat);
        // R7: byte and halfword lanes
        rd(16'h0021, 2'd0, 0, "R7", lat);
        rd(16'h0022, 2'd0, 0, "R7", lat);
        rd(16'h0023, 2'd0, 0, "R7", lat);
        rd(16'h0022, 2'd1, 0, "R7", lat);
        rd(16'h0026, 2'd1, 0, "R7", lat);
        // R6: alias of line 2 one flash size higher
        rd(16'h1024, 2'd2, 0, "R6", lat);
        // R6: last line, then wrap to line 0 via prefetch
        rd(16'h0FF0, 2'd2, 3, "R6", lat);
        rd(16'h0FF4, 2'd2, 0, "R6", lat);
        rd(16'h0FF8, 2'd2, 0, "R6", lat);
        rd(16'h0FFC, 2'd2, 0, "R6", lat);
        rd(16'h2000, 2'd2, 0, "R6", lat);
        // R8: invalidate empties buffers
        idle(2);
        @(negedge clk);
        invalidate = 1'b1;
        @(negedge clk);
        invalidate = 1'b0;
        #4;
        check("R8", "fl_en after invalidate", 32'(fl_en), 32'd0);
        rd(16'h2004, 2'd2, 3, "R8", lat);

        // R3: single-cycle flash access
        set_ws(0);
        rd(16'h0500, 2'd2, 1, "R3", lat);
        for (int i = 1; i < 8; i++) rd(16'h0500 + 16'(4 * i), 2'd2, 0, "R3", lat);

        // R9: abandon prefetch on a miss elsewhere; join an in-flight line
        set_ws(5);
        rd(16'h00A0, 2'd2, 6, "R9", lat);
        rd(16'h0400, 2'd2, 6, "R9", lat);
        rd(16'h00B0, 2'd2, 6, "R9", lat);
        rd(16'h00C0, 2'd2, 5, "R9", lat);

        // Random mix of sequential runs, jumps, sizes and gaps
        a = 16'h0200;
        for (int i = 0; i < 400; i++) begin
            if (i % 100 == 0) set_ws(int'($urandom_range(0, 3)));
            if ($urandom_range(0, 9) < 7) a = a + 16'd4;
            else a = 16'($urandom) & 16'hFFFC;
            sz = 2'($urandom_range(0, 2));
            case (sz)
                2'd0:    ad = a + 16'($urandom_range(0, 3));
                2'd1:    ad = a + 16'(2 * $urandom_range(0, 1));
                default: ad = a;
            endcase
            rd(ad, sz, -1, "R1", lat);
            // R2: stall never exceeds wait_states+1
            check("R2", "stall bound", 32'(lat <= int'(wait_states) + 1), 32'd1);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end

        idle(2);
        summary();
        $finish;
    end
endmodule